// File: doc/BRIEF.md
# Nonvolatile Memory Write-Unlock Controller

This block sits between the processor's register bus and the nonvolatile memory. It accepts a write to that memory only after a fixed two-step key has been written to an unlock port and a start bit has then been set. It holds the target address in a pointer made of byte-wide lanes, selects the target space (program flash or data EEPROM, and configuration space or main array), and stalls the processor for a programmable busy time while the write runs. The memory array is not modelled; the block only issues a one-cycle launch pulse and raises a done pulse when the busy time runs out.

The unlock port has no storage. Writes to it only move a small sequence tracker forward or send it back to idle, and reads of it always return zero. Two resets are used. A power-on reset clears everything. A warm reset, raised by an external reset pin or by a watchdog timeout, clears all state except an error flag. That flag is set when a warm reset cuts a write short, so software can find and rewrite the damaged location.

The register bus carries one access per cycle with no handshake. Reads return data in the same cycle. While the processor is stalled the bus is ignored.

Top module: `nvm_unlock_ctrl`

## Requirements
- R1: The register offsets are: 0 = control, 1 = unlock port, 2/3/4 = pointer lanes (bits 7:0, 15:8, 20:16). The control bits are: 7 = program-flash select, 6 = configuration select, 3 = error flag, 2 = write enable, 1 = start. Control bits 5, 4 and 0 read as 0. After power-on reset every register reads 0.
- R2: A read of the unlock port returns 0, whatever was written to it before.
- R3: A write is launched only by this sequence, with write enable already set: a write of 55h to the unlock port, then a write of AAh to the unlock port, then a control write with bit 1 set. Idle cycles with no access may fall between these steps. `mem_wr_start` pulses for one cycle, and `cpu_stall` rises, in the cycle after the launching control write.
- R4: A control write with the start bit set has no effect when write enable was 0 before that write.
- R5: The key sequence returns to idle on any of these: a wrong key value, a repeated first key, or any other access (a read or a write at any offset) between the key writes and the start write. A later start write then does not launch.
- R6: When write enable is cleared part-way through the key sequence, the sequence returns to idle.
- R7: `cpu_stall` stays high for exactly BUSY_CYCLES cycles. `mem_done` is high only in the last of these cycles. The start bit reads 1 while the write is busy and 0 afterwards.
- R8: While `cpu_stall` is high, bus writes change no register.
- R9: A warm reset while the write is busy sets the error flag. A warm reset clears every other register. The error flag is cleared only by power-on reset or by a control write with bit 3 at 0; a write of 1 leaves it unchanged.
- R10: The pointer is 21 bits wide. The upper lane stores 5 bits, and its bits 7:5 read as 0. `mem_addr` always shows the pointer.
- R11: `mem_sel_prog` and `mem_sel_cfg` follow control bits 7 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_n | input | 1 | External or watchdog reset, active low, sampled on the clock |
| bus_valid | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| cpu_stall | output | 1 | Processor stall while a write is busy |
| mem_wr_start | output | 1 | One-cycle launch pulse to the memory |
| mem_done | output | 1 | High in the last busy cycle |
| mem_sel_prog | output | 1 | 1 = program flash, 0 = data EEPROM |
| mem_sel_cfg | output | 1 | 1 = configuration space |
| mem_addr | output | 21 | Write address from the pointer |

## Verification
The assertions assume the following about the inputs:
- At most one access per cycle.
- Bus inputs stay stable between clock edges.
- `por_n` is low at time zero.
- `warm_rst_n` is held low across at least one rising edge.

The stimulus drives every input on the falling edge, one access per task call. It starts under power-on reset and pulses each reset for a whole cycle. During a busy window it issues only one read and one write, to confirm that the write is ignored. Key sequences are broken in each way the requirements name, and each break is followed by a start write that must not launch.

// File: rtl/nvm_unlock_pkg.sv
package nvm_unlock_pkg;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_KEY  = 3'd1;
  localparam logic [2:0] A_PTR0 = 3'd2;

  localparam int B_START = 1;
  localparam int B_WREN  = 2;
  localparam int B_ERR   = 3;
  localparam int B_CFG   = 6;
  localparam int B_PROG  = 7;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_HALF  = 2'd1,
    SEQ_ARMED = 2'd2
  } seq_e;

  typedef struct packed {
    logic       valid;
    logic       we;
    logic [2:0] addr;
    logic [7:0] data;
  } bus_acc_t;

endpackage

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
  import nvm_unlock_pkg::*;
#(
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic     clk,
  input  logic     por_n,
  input  logic     warm_rst_n,
  input  bus_acc_t acc,
  input  logic     wren_q,
  output logic     launch,
  output logic     armed
);

  seq_e st, nxt;

  always_comb begin
    nxt = st;
    if (!wren_q) begin
      nxt = SEQ_IDLE;
    end else if (acc.valid) begin
      if (acc.we && acc.addr == A_KEY) begin
        case (st)
          SEQ_IDLE: nxt = (acc.data == KEY_A) ? SEQ_HALF : SEQ_IDLE;
          SEQ_HALF: nxt = (acc.data == KEY_B) ? SEQ_ARMED : SEQ_IDLE;
          default:  nxt = SEQ_IDLE;
        endcase
      end else begin
        nxt = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           st <= SEQ_IDLE;
    else if (!warm_rst_n) st <= SEQ_IDLE;
    else                  st <= nxt;
  end

  assign armed  = (st == SEQ_ARMED);
  assign launch = acc.valid && acc.we && (acc.addr == A_CTRL) &&
                  armed && acc.data[B_START] && wren_q;

  // R3: the armed state is reached only through a second-key write
  a_r3_armed_after_key_b: assert property (@(posedge clk) disable iff (!por_n)
    $rose(armed) |-> $past(acc.valid && acc.we && acc.addr == A_KEY &&
                           acc.data == KEY_B && warm_rst_n));

  // R6: with write enable low the tracker is back at idle one cycle later
  a_r6_wren_low_idles: assert property (@(posedge clk) disable iff (!por_n)
    !wren_q |=> (st == SEQ_IDLE));

endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic warm_rst_n,
  input  logic launch,
  output logic busy,
  output logic done
);

  localparam int CW = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!warm_rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (launch && !busy) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  // R7: the done cycle is the final stall cycle
  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!por_n)
    (done && warm_rst_n) |=> !busy);

  // R7: no early release before done
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!por_n)
    (busy && !done && warm_rst_n) |=> busy);

endmodule

// File: rtl/nvm_ptr_regs.sv
module nvm_ptr_regs
  import nvm_unlock_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  bus_acc_t          acc,
  output logic [ADDR_W-1:0] ptr,
  output logic [7:0]        rd_data
);

  localparam int NLANE = (ADDR_W + 7) / 8;

  logic [NLANE-1:0][7:0] lane_rd;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int LO = 8 * i;
    localparam int W  = ((ADDR_W - LO) > 8) ? 8 : (ADDR_W - LO);
    logic [W-1:0] q;

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)           q <= '0;
      else if (!warm_rst_n) q <= '0;
      else if (acc.valid && acc.we && acc.addr == (A_PTR0 + 3'(i)))
        q <= acc.data[W-1:0];
    end

    assign ptr[LO +: W] = q;
    assign lane_rd[i]   = 8'(q);
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (acc.addr == (A_PTR0 + 3'(i))) rd_data = lane_rd[i];
    end
  end

  // R8: without a bus write the pointer holds its value
  a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (!por_n)
    (!(acc.valid && acc.we) && warm_rst_n) |=> $stable(ptr));

endmodule

// File: rtl/nvm_unlock_ctrl.sv
module nvm_unlock_ctrl
  import nvm_unlock_pkg::*;
#(
  parameter int         ADDR_W      = 21,
  parameter int         BUSY_CYCLES = 8,
  parameter logic [7:0] KEY_A       = 8'h55,
  parameter logic [7:0] KEY_B       = 8'hAA
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              cpu_stall,
  output logic              mem_wr_start,
  output logic              mem_done,
  output logic              mem_sel_prog,
  output logic              mem_sel_cfg,
  output logic [ADDR_W-1:0] mem_addr
);

  bus_acc_t   acc;
  logic       busy, launch, armed;
  logic       wren_q, prog_q, cfg_q, err_q;
  logic [7:0] ptr_rd;
  logic       ctrl_wr;

  assign acc.valid = bus_valid && !busy;
  assign acc.we    = bus_we;
  assign acc.addr  = bus_addr;
  assign acc.data  = bus_wdata;
  assign ctrl_wr   = acc.valid && acc.we && (acc.addr == A_CTRL);

  nvm_key_seq #(.KEY_A(KEY_A), .KEY_B(KEY_B)) i_seq (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_n (warm_rst_n),
    .acc        (acc),
    .wren_q     (wren_q),
    .launch     (launch),
    .armed      (armed)
  );

  nvm_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) i_timer (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_n (warm_rst_n),
    .launch     (launch),
    .busy       (busy),
    .done       (mem_done)
  );

  nvm_ptr_regs #(.ADDR_W(ADDR_W)) i_ptr (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_n (warm_rst_n),
    .acc        (acc),
    .ptr        (mem_addr),
    .rd_data    (ptr_rd)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wren_q       <= 1'b0;
      prog_q       <= 1'b0;
      cfg_q        <= 1'b0;
      mem_wr_start <= 1'b0;
    end else if (!warm_rst_n) begin
      wren_q       <= 1'b0;
      prog_q       <= 1'b0;
      cfg_q        <= 1'b0;
      mem_wr_start <= 1'b0;
    end else begin
      mem_wr_start <= launch;
      if (ctrl_wr) begin
        wren_q <= bus_wdata[B_WREN];
        prog_q <= bus_wdata[B_PROG];
        cfg_q  <= bus_wdata[B_CFG];
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                            err_q <= 1'b0;
    else if (!warm_rst_n)                  err_q <= err_q | busy;
    else if (ctrl_wr && !bus_wdata[B_ERR]) err_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_PROG]  = prog_q;
        bus_rdata[B_CFG]   = cfg_q;
        bus_rdata[B_ERR]   = err_q;
        bus_rdata[B_WREN]  = wren_q;
        bus_rdata[B_START] = busy;
      end
      A_KEY:   bus_rdata = '0;
      default: bus_rdata = ptr_rd;
    endcase
  end

  assign cpu_stall    = busy;
  assign mem_sel_prog = prog_q;
  assign mem_sel_cfg  = cfg_q;

  // R9: cutting a busy write with warm reset leaves the error flag set
  a_r9_err_on_cut: assert property (@(posedge clk) disable iff (!por_n)
    (!warm_rst_n && cpu_stall) |=> err_q);

  // R4: start with write enable low never stalls
  a_r4_start_needs_wren: assert property (@(posedge clk) disable iff (!por_n)
    (ctrl_wr && bus_wdata[B_START] && !wren_q && warm_rst_n) |=> !cpu_stall);

  // R3: stall begins together with the launch pulse
  a_r3_stall_with_pulse: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cpu_stall) |-> mem_wr_start);

endmodule

// File: tb/test_nvm_unlock_ctrl.sv
`timescale 1ns/1ps
module test_nvm_unlock_ctrl;

  localparam int BUSY = 8;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst_n = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic        cpu_stall, mem_wr_start, mem_done, mem_sel_prog, mem_sel_cfg;
  logic [20:0] mem_addr;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nvm_unlock_ctrl #(.ADDR_W(21), .BUSY_CYCLES(BUSY)) i_nvm_unlock_ctrl (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_stall(cpu_stall),
    .mem_wr_start(mem_wr_start), .mem_done(mem_done),
    .mem_sel_prog(mem_sel_prog), .mem_sel_cfg(mem_sel_cfg), .mem_addr(mem_addr)
  );

  // behavioural reference model
  bit          m_wren, m_prog, m_cfg, m_err, m_pulse;
  int          m_seq;
  int          m_left;
  logic [20:0] m_ptr;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_wren = 0; m_prog = 0; m_cfg = 0; m_err = 0; m_pulse = 0;
      m_seq = 0; m_left = 0; m_ptr = '0;
    end else if (!warm_rst_n) begin
      if (m_left > 0) m_err = 1;
      m_wren = 0; m_prog = 0; m_cfg = 0; m_pulse = 0;
      m_seq = 0; m_left = 0; m_ptr = '0;
    end else begin
      m_pulse = 0;
      if (m_left > 0) begin
        m_left = m_left - 1;
      end else if (bus_valid) begin
        if (bus_we && bus_addr == 3'd0) begin
          if (m_seq == 2 && bus_wdata[1] && m_wren) begin
            m_left = BUSY; m_pulse = 1;
          end
          m_wren = bus_wdata[2]; m_prog = bus_wdata[7]; m_cfg = bus_wdata[6];
          if (!bus_wdata[3]) m_err = 0;
          m_seq = 0;
        end else if (bus_we && bus_addr == 3'd1) begin
          if (!m_wren) m_seq = 0;
          else if (m_seq == 0 && bus_wdata == 8'h55) m_seq = 1;
          else if (m_seq == 1 && bus_wdata == 8'hAA) m_seq = 2;
          else m_seq = 0;
        end else begin
          if (bus_we) begin
            case (bus_addr)
              3'd2: m_ptr[7:0]   = bus_wdata;
              3'd3: m_ptr[15:8]  = bus_wdata;
              3'd4: m_ptr[20:16] = bus_wdata[4:0];
              default: ;
            endcase
          end
          m_seq = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return {m_prog, m_cfg, 2'b00, m_err, m_wren, (m_left > 0), 1'b0};
      3'd2: return m_ptr[7:0];
      3'd3: return m_ptr[15:8];
      3'd4: return {3'b000, m_ptr[20:16]};
      default: return 8'h00;
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (por_n && !finished) begin
      chk(cpu_stall === (m_left > 0), "R7 stall", cpu_stall, m_left > 0);
      chk(mem_done === (m_left == 1), "R7 done", mem_done, m_left == 1);
      chk(mem_wr_start === m_pulse, "R3 pulse", mem_wr_start, m_pulse);
      chk(mem_addr === m_ptr, "R10 addr", mem_addr, m_ptr);
      chk(mem_sel_prog === m_prog && mem_sel_cfg === m_cfg, "R11 select",
          {mem_sel_prog, mem_sel_cfg}, {m_prog, m_cfg});
      if (bus_valid && !bus_we)
        chk(bus_rdata === model_rd(bus_addr), "R1 read data", bus_rdata,
            model_rd(bus_addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_valid = 0; bus_we = 0;
    end
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_valid = 1; bus_we = 0; bus_addr = a;
    #2;
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic no_launch(input string tag);
    nop(1);
    #2;
    chk(cpu_stall === 1'b0 && mem_wr_start === 1'b0, tag, cpu_stall, 0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual run still going, expected end");
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    int done_at;
    repeat (3) @(negedge clk);
    por_n = 1;
    // R1 reset state
    rd_chk(3'd0, 8'h00, "R1 reset ctrl");
    rd_chk(3'd4, 8'h00, "R1 reset ptr");
    // R10 pointer lanes
    wr(3'd2, 8'h34); wr(3'd3, 8'h12); wr(3'd4, 8'hFF);
    rd_chk(3'd4, 8'h1F, "R10 upper lane");
    rd_chk(3'd2, 8'h34, "R10 low lane");
    #1 chk(mem_addr === 21'h1F1234, "R10 mem_addr", mem_addr, 21'h1F1234);
    // R2 unlock port reads zero
    wr(3'd1, 8'h55);
    rd_chk(3'd1, 8'h00, "R2 key read");
    // R4 start without write enable
    wr(3'd0, 8'h02);
    no_launch("R4 start ignored");
    rd_chk(3'd0, 8'h00, "R4 ctrl after");
    // R11 / R1 enable with program select
    wr(3'd0, 8'h84);
    rd_chk(3'd0, 8'h84, "R1 ctrl bits");
    #1 chk(mem_sel_prog === 1'b1, "R11 prog select", mem_sel_prog, 1);
    // R3 good launch with idle gap
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); nop(2); wr(3'd0, 8'h86);
    nop(1); #2;
    chk(cpu_stall === 1'b1 && mem_wr_start === 1'b1, "R3 launch", {cpu_stall, mem_wr_start}, 2'b11);
    rd_chk(3'd0, 8'h86, "R7 start reads 1");
    wr(3'd2, 8'h5A);
    c = 3; done_at = 0;
    for (int k = 0; k < 20; k++) begin
      nop(1); #2;
      if (cpu_stall) begin
        c++;
        if (mem_done) done_at = c;
      end else break;
    end
    chk(c == BUSY, "R7 stall length", c, BUSY);
    chk(done_at == BUSY, "R7 done position", done_at, BUSY);
    rd_chk(3'd2, 8'h34, "R8 write during busy ignored");
    rd_chk(3'd0, 8'h84, "R7 start cleared");
    // R5 broken sequences
    wr(3'd1, 8'hAA); wr(3'd1, 8'h55); wr(3'd0, 8'h86); no_launch("R5 reversed keys");
    wr(3'd1, 8'h55); wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h86); no_launch("R5 repeated key");
    wr(3'd1, 8'h55); rd_chk(3'd2, 8'h34, "R5 read between");
    wr(3'd1, 8'hAA); wr(3'd0, 8'h86); no_launch("R5 read breaks sequence");
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd3, 8'h12); wr(3'd0, 8'h86); no_launch("R5 write breaks sequence");
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h84); wr(3'd0, 8'h86); no_launch("R5 ctrl without start");
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd1, 8'h55); wr(3'd0, 8'h86); no_launch("R5 extra key");
    // R6 clearing enable mid-sequence
    wr(3'd1, 8'h55); wr(3'd0, 8'h80); wr(3'd0, 8'h84); wr(3'd1, 8'hAA); wr(3'd0, 8'h86);
    no_launch("R6 enable cleared");
    // R11 configuration select
    wr(3'd0, 8'h44); nop(1); #2;
    chk(mem_sel_cfg === 1'b1 && mem_sel_prog === 1'b0, "R11 cfg select",
        {mem_sel_cfg, mem_sel_prog}, 2'b10);
    // R9 warm reset during busy
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h46); nop(3);
    @(negedge clk); warm_rst_n = 0;
    @(negedge clk); warm_rst_n = 1;
    rd_chk(3'd0, 8'h08, "R9 error set by cut");
    rd_chk(3'd2, 8'h00, "R9 pointer cleared");
    @(negedge clk); bus_valid = 0; warm_rst_n = 0;
    @(negedge clk); warm_rst_n = 1;
    rd_chk(3'd0, 8'h08, "R9 error survives warm reset");
    wr(3'd0, 8'h08);
    rd_chk(3'd0, 8'h08, "R9 write 1 keeps error");
    wr(3'd0, 8'h00);
    rd_chk(3'd0, 8'h00, "R9 write 0 clears error");
    // R9 power-on reset clears the flag
    wr(3'd0, 8'h04); wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h06); nop(2);
    @(negedge clk); warm_rst_n = 0;
    @(negedge clk); warm_rst_n = 1;
    rd_chk(3'd0, 8'h08, "R9 error set again");
    @(negedge clk); bus_valid = 0; por_n = 0;
    @(negedge clk); por_n = 1;
    rd_chk(3'd0, 8'h00, "R9 power-on clears error");
    nop(3);
    finished = 1;
    summary();
    $finish;
  end

endmodule